// File: doc/BRIEF.md
# Transfer Activation Priority Gate

This block sits between the sources that start data transfers and the transfer engines themselves. One engine is a descriptor-driven transfer controller. The others are the channels of a multi-channel DMA controller. Each engine has its own 3-bit priority level, and so does the CPU. While gating is switched on, an activation request from an engine whose level is below the CPU level is held back. This lets the CPU finish interrupt handling before lower-priority bus traffic starts.

A held request is not lost. It stays pending and is issued as one activation strobe as soon as the CPU level no longer exceeds the engine's level, or as soon as gating is switched off. The CPU level can be written by software. It can also follow the CPU interrupt mask on its own, using either a single mask bit or a 3-bit mask field.

Top module: `xfer_prio_gate`

## Requirements
- R1: While `rst_n` is low on a clock edge, every level, the enable bit and the auto-assign bit clear to 0, no request is pending, and every activation output is 0 after that edge.
- R2: While the enable bit is 0, a request on any source in one cycle produces an activation strobe on that source's output in the next cycle.
- R3: While the enable bit is 1, a source whose level is strictly below the CPU level produces no activation strobe.
- R4: While the enable bit is 1, a source whose level is equal to or above the CPU level passes each request as a strobe in the next cycle.
- R5: A request that is held becomes pending. Any number of further requests from that source while it is pending merge into it. Exactly one strobe is issued in the cycle after the edge where the hold condition ends, whether the CPU level was lowered or gating was disabled.
- R6: Each of the 4 DMA channels is compared with the CPU level on its own, so higher channels keep passing while lower ones are held.
- R7: The transfer controller is gated by its single level field, whatever the source of its request.
- R8: With auto-assign set and `mask_sel`=1, the CPU level takes the value of `imask_lvl` at every clock edge.
- R9: With auto-assign set and `mask_sel`=0, the CPU level becomes 7 when `imask_bit` is 1 and 0 when it is 0.
- R10: With auto-assign clear, the CPU level changes only through a write to address 0, and the mask inputs have no effect.
- R11: While auto-assign is set, including in the write that sets it, the CPU level bits of a write to address 0 are discarded.
- R12: A write to address 0 loads enable from bit 7, auto-assign from bit 6, the transfer controller level from bits 5:3 and the CPU level from bits 2:0. A write to address 1+k loads the level of DMA channel k from bits 2:0. Writes to addresses 5 to 7 change nothing. A written value governs gating from the following clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_we | input | 1 | Register write enable |
| cfg_addr | input | 3 | Register address |
| cfg_wdata | input | 8 | Register write data |
| mask_sel | input | 1 | Interrupt mask style: 0 single bit, 1 three-bit field |
| imask_bit | input | 1 | CPU single interrupt mask bit |
| imask_lvl | input | 3 | CPU three-bit interrupt mask field |
| xfer_req | input | 1 | Raw activation request to the transfer controller |
| dma_req | input | 4 | Raw activation requests, one per DMA channel |
| xfer_act | output | 1 | Gated activation strobe to the transfer controller |
| dma_act | output | 4 | Gated activation strobes, one per DMA channel |
| cpu_lvl_o | output | 3 | Current CPU priority level |

## Verification
The directed part uses fixed channel levels of 7, 5, 4 and 0 against a CPU level of 5. This separates strictly-below from equal-or-above on each channel independently. Repeated pulses on a held channel, followed by release through a lower CPU level and then through disabling, show that requests are merged and not dropped. Auto-assign is tried in both mask styles, with software writes to the CPU field mixed in, to separate tracking from manual control. Seeded random writes, mask changes and request patterns then check every cycle against a bench model built from the requirements.

// File: rtl/prio_gate_pkg.sv
// Package: shared types and constants for the transfer activation priority gate.
// Assumes 3-bit priority levels and an 8-bit control word.
package prio_gate_pkg;

    localparam int LVL_W = 3;

    // Control word layout; the packing order fixes the bit positions software writes.
    typedef struct packed {
        logic             gate_en;
        logic             auto_set;
        logic [LVL_W-1:0] xfer_lvl;
        logic [LVL_W-1:0] cpu_lvl;
    } ctrl_t;

    localparam int DATA_W = $bits(ctrl_t);

endpackage

// File: rtl/prio_gate_mask.sv
// Module: maps the CPU interrupt mask onto a CPU priority level.
// Assumes a single mask bit maps to all-ones when set and zero when clear.
module prio_gate_mask
    import prio_gate_pkg::*;
(
    input  logic             mask_sel,
    input  logic             imask_bit,
    input  logic [LVL_W-1:0] imask_lvl,
    output logic [LVL_W-1:0] mask_lvl
);

    // Choose the field directly, or widen the single bit.
    always_comb begin
        if (mask_sel) begin
            mask_lvl = imask_lvl;
        end else begin
            mask_lvl = {LVL_W{imask_bit}};
        end
    end

endmodule

// File: rtl/prio_gate_regs.sv
// Module: control and per-channel level registers, with CPU level auto-assign.
// Assumes address 0 is the control word and address 1+k is channel k.
// While auto-assign is set, the CPU level is reloaded from the mask every cycle.
module prio_gate_regs
    import prio_gate_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int ADDR_W = 3
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         cfg_we,
    input  logic [ADDR_W-1:0]            cfg_addr,
    input  logic [DATA_W-1:0]            cfg_wdata,
    input  logic [LVL_W-1:0]             mask_lvl,
    output ctrl_t                        ctrl_q,
    output logic [NUM_CH-1:0][LVL_W-1:0] ch_lvl_q
);

    localparam logic [ADDR_W-1:0] CTRL_ADDR = '0;

    logic  wr_ctrl;
    ctrl_t wr_word;
    logic  auto_nx;

    // Decode a control write and find the auto-assign state after this edge.
    always_comb begin
        wr_ctrl = cfg_we && (cfg_addr == CTRL_ADDR);
        wr_word = ctrl_t'(cfg_wdata);
        auto_nx = wr_ctrl ? wr_word.auto_set : ctrl_q.auto_set;
    end

    // Control word update; the CPU field follows the mask whenever auto-assign is on.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else begin
            if (wr_ctrl) begin
                ctrl_q.gate_en  <= wr_word.gate_en;
                ctrl_q.auto_set <= wr_word.auto_set;
                ctrl_q.xfer_lvl <= wr_word.xfer_lvl;
            end
            if (auto_nx) begin
                ctrl_q.cpu_lvl <= mask_lvl;
            end else if (wr_ctrl) begin
                ctrl_q.cpu_lvl <= wr_word.cpu_lvl;
            end
        end
    end

    for (genvar k = 0; k < NUM_CH; k++) begin : g_ch
        localparam logic [ADDR_W-1:0] CH_ADDR = ADDR_W'(k + 1);

        // Channel level register, loaded by a write to its own address.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ch_lvl_q[k] <= '0;
            end else if (cfg_we && (cfg_addr == CH_ADDR)) begin
                ch_lvl_q[k] <= cfg_wdata[LVL_W-1:0];
            end
        end
    end

endmodule

// File: rtl/prio_gate_lane.sv
// Module: gating lane for one requester: holds, merges and releases requests.
// Assumes req is one activation per cycle it is high; act is a registered strobe.
module prio_gate_lane
    import prio_gate_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             gate_en,
    input  logic [LVL_W-1:0] cpu_lvl,
    input  logic [LVL_W-1:0] own_lvl,
    input  logic             req,
    output logic             held,
    output logic             act,
    output logic             pend
);

    logic want;

    // The lane is held when gating is on and the CPU outranks it.
    always_comb begin
        held = gate_en && (own_lvl < cpu_lvl);
        want = req || pend;
    end

    // Issue a strobe when free, otherwise keep a single merged pending flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act  <= 1'b0;
            pend <= 1'b0;
        end else begin
            act  <= want && !held;
            pend <= want && held;
        end
    end

endmodule

// File: rtl/xfer_prio_gate.sv
// Module: top of the transfer activation priority gate.
// Lane 0 serves the transfer controller; lanes 1..NUM_CH serve DMA channels.
// Assumes requests are single-cycle pulses per activation and a synchronous reset.
module xfer_prio_gate
    import prio_gate_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int ADDR_W = $clog2(NUM_CH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [DATA_W-1:0] cfg_wdata,
    input  logic              mask_sel,
    input  logic              imask_bit,
    input  logic [LVL_W-1:0]  imask_lvl,
    input  logic              xfer_req,
    input  logic [NUM_CH-1:0] dma_req,
    output logic              xfer_act,
    output logic [NUM_CH-1:0] dma_act,
    output logic [LVL_W-1:0]  cpu_lvl_o
);

    localparam int NUM_LANE = NUM_CH + 1;

    ctrl_t                          ctrl_q;
    logic [NUM_CH-1:0][LVL_W-1:0]   ch_lvl_q;
    logic [LVL_W-1:0]               mask_lvl;
    logic [NUM_LANE-1:0][LVL_W-1:0] lvl_vec;
    logic [NUM_LANE-1:0]            req_vec;
    logic [NUM_LANE-1:0]            act_vec;
    logic [NUM_LANE-1:0]            pend_vec;
    logic [NUM_LANE-1:0]            held_vec;

    prio_gate_mask u_mask (
        .mask_sel  (mask_sel),
        .imask_bit (imask_bit),
        .imask_lvl (imask_lvl),
        .mask_lvl  (mask_lvl)
    );

    prio_gate_regs #(
        .NUM_CH (NUM_CH),
        .ADDR_W (ADDR_W)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .mask_lvl  (mask_lvl),
        .ctrl_q    (ctrl_q),
        .ch_lvl_q  (ch_lvl_q)
    );

    // Gather lane levels and requests into one indexed view.
    always_comb begin
        lvl_vec[0] = ctrl_q.xfer_lvl;
        req_vec[0] = xfer_req;
        for (int k = 0; k < NUM_CH; k++) begin
            lvl_vec[k+1] = ch_lvl_q[k];
            req_vec[k+1] = dma_req[k];
        end
    end

    for (genvar i = 0; i < NUM_LANE; i++) begin : g_lane
        prio_gate_lane u_lane (
            .clk     (clk),
            .rst_n   (rst_n),
            .gate_en (ctrl_q.gate_en),
            .cpu_lvl (ctrl_q.cpu_lvl),
            .own_lvl (lvl_vec[i]),
            .req     (req_vec[i]),
            .held    (held_vec[i]),
            .act     (act_vec[i]),
            .pend    (pend_vec[i])
        );
    end

    // Drive the outputs from the lane strobes and the CPU level register.
    always_comb begin
        xfer_act  = act_vec[0];
        dma_act   = act_vec[NUM_LANE-1:1];
        cpu_lvl_o = ctrl_q.cpu_lvl;
    end

endmodule

// File: rtl/xfer_prio_gate_chk.sv
// Module: assertion checker for xfer_prio_gate, attached with bind.
// Assumes lane 0 is the transfer controller and lanes 1..NUM_CH the DMA channels.
module xfer_prio_gate_chk
    import prio_gate_pkg::*;
#(
    parameter int NUM_LANE = 5
) (
    input logic                           clk,
    input logic                           rst_n,
    input logic                           cfg_we,
    input logic                           gate_en,
    input logic                           auto_on,
    input logic                           mask_sel,
    input logic                           imask_bit,
    input logic [LVL_W-1:0]               imask_lvl,
    input logic [LVL_W-1:0]               cpu_lvl,
    input logic [NUM_LANE-1:0][LVL_W-1:0] lvl_vec,
    input logic [NUM_LANE-1:0]            req_vec,
    input logic [NUM_LANE-1:0]            act_vec,
    input logic [NUM_LANE-1:0]            pend_vec
);

    AST_AUTO_FIELD: assert property (@(posedge clk) disable iff (!rst_n)
        auto_on && !cfg_we && mask_sel |=> cpu_lvl == $past(imask_lvl)); // R8

    AST_AUTO_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        auto_on && !cfg_we && !mask_sel |=> cpu_lvl == {LVL_W{$past(imask_bit)}}); // R9

    AST_MANUAL_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !auto_on && !cfg_we |=> $stable(cpu_lvl)); // R10

    for (genvar i = 0; i < NUM_LANE; i++) begin : g_lane_chk
        AST_PASS_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
            !gate_en && req_vec[i] |=> act_vec[i]); // R2

        AST_HOLD_BELOW: assert property (@(posedge clk) disable iff (!rst_n)
            gate_en && (lvl_vec[i] < cpu_lvl) |=> !act_vec[i]); // R3

        AST_PASS_AT_OR_ABOVE: assert property (@(posedge clk) disable iff (!rst_n)
            gate_en && (lvl_vec[i] >= cpu_lvl) && req_vec[i] |=> act_vec[i]); // R4

        AST_KEEP_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
            gate_en && (lvl_vec[i] < cpu_lvl) && req_vec[i] |=> pend_vec[i]); // R5

        AST_RELEASE_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
            pend_vec[i] && !(gate_en && (lvl_vec[i] < cpu_lvl)) |=> act_vec[i] && !pend_vec[i]); // R5
    end

endmodule

bind xfer_prio_gate xfer_prio_gate_chk #(
    .NUM_LANE (NUM_CH + 1)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .gate_en   (ctrl_q.gate_en),
    .auto_on   (ctrl_q.auto_set),
    .mask_sel  (mask_sel),
    .imask_bit (imask_bit),
    .imask_lvl (imask_lvl),
    .cpu_lvl   (ctrl_q.cpu_lvl),
    .lvl_vec   (lvl_vec),
    .req_vec   (req_vec),
    .act_vec   (act_vec),
    .pend_vec  (pend_vec)
);

// File: tb/xfer_prio_gate_tb.sv
// Bench: directed corner cases plus seeded random traffic, checked every cycle
// against a model written from the requirements.
module xfer_prio_gate_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0;
    logic [2:0] cfg_addr = '0;
    logic [7:0] cfg_wdata = '0;
    logic       mask_sel = 1'b0;
    logic       imask_bit = 1'b0;
    logic [2:0] imask_lvl = '0;
    logic       xfer_req = 1'b0;
    logic [3:0] dma_req = '0;
    logic       xfer_act;
    logic [3:0] dma_act;
    logic [2:0] cpu_lvl_o;

    int    n_chk = 0;
    int    n_bad = 0;
    bit    run_chk = 1'b0;
    bit    done = 1'b0;
    string tag = "R1";

    xfer_prio_gate u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .mask_sel  (mask_sel),
        .imask_bit (imask_bit),
        .imask_lvl (imask_lvl),
        .xfer_req  (xfer_req),
        .dma_req   (dma_req),
        .xfer_act  (xfer_act),
        .dma_act   (dma_act),
        .cpu_lvl_o (cpu_lvl_o)
    );

    always #5 clk = ~clk;

    // Model state; index 0 is the transfer controller, 1..4 the DMA channels.
    logic [2:0] m_cpu, m_xl;
    logic       m_en, m_auto;
    logic [2:0] m_ch [4];
    logic [4:0] m_pend, m_act;

    function automatic logic [2:0] mask_to_lvl(logic sel, logic b, logic [2:0] f);
        return sel ? f : (b ? 3'd7 : 3'd0);
    endfunction

    function automatic logic [2:0] lane_lvl(int i);
        return (i == 0) ? m_xl : m_ch[i-1];
    endfunction

    // Model update at each edge, from the requirements.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_cpu = 0; m_xl = 0; m_en = 0; m_auto = 0; m_pend = 0; m_act = 0;
            for (int k = 0; k < 4; k++) m_ch[k] = 0;
        end else begin
            logic [4:0] rq;
            logic       held;
            logic       auto_n;
            rq = {dma_req, xfer_req};
            for (int i = 0; i < 5; i++) begin
                held      = m_en && (lane_lvl(i) < m_cpu);
                m_act[i]  = (rq[i] || m_pend[i]) && !held;
                m_pend[i] = (rq[i] || m_pend[i]) && held;
            end
            auto_n = m_auto;
            if (cfg_we && cfg_addr == 3'd0) begin
                m_en   = cfg_wdata[7];
                auto_n = cfg_wdata[6];
                m_xl   = cfg_wdata[5:3];
            end
            if (auto_n) m_cpu = mask_to_lvl(mask_sel, imask_bit, imask_lvl);
            else if (cfg_we && cfg_addr == 3'd0) m_cpu = cfg_wdata[2:0];
            m_auto = auto_n;
            if (cfg_we && cfg_addr >= 3'd1 && cfg_addr <= 3'd4)
                m_ch[cfg_addr-1] = cfg_wdata[2:0];
        end
    end

    task automatic check(string t, logic [7:0] act, logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h at %0t", t, act, exp, $time);
        end
    endtask

    // Compare outputs with the model away from the active edge.
    always @(negedge clk) begin
        if (run_chk) begin
            check(tag, {dma_act, xfer_act}, {3'b0, m_act});
            check(tag, {5'b0, cpu_lvl_o}, {5'b0, m_cpu});
        end
    end

    task automatic tick();
        @(negedge clk);
        cfg_we   = 1'b0;
        xfer_req = 1'b0;
        dma_req  = '0;
    endtask

    task automatic wr(logic [2:0] a, logic [7:0] d);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        tick();
    endtask

    task automatic pulse(logic x, logic [3:0] d);
        xfer_req = x; dma_req = d;
        tick();
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        int seed_dummy;
        seed_dummy = $urandom(32'h5eed_0042);
        // R1: reset state at the ports.
        repeat (3) @(negedge clk);
        check("R1 strobes", {3'b0, dma_act, xfer_act}, 8'h00);
        check("R1 cpu level", {5'b0, cpu_lvl_o}, 8'h00);
        rst_n = 1'b1;
        run_chk = 1'b1;
        tick();

        // R2: pass-through while disabled.
        tag = "R2";
        pulse(1'b1, 4'hF); pulse(1'b0, 4'h5); tick();

        // R12: register layout; en=1, auto=0, xfer=2, cpu=5; channels 7,5,4,0.
        tag = "R12";
        wr(3'd0, {1'b1, 1'b0, 3'd2, 3'd5});
        wr(3'd1, 8'd7); wr(3'd2, 8'd5); wr(3'd3, 8'd4); wr(3'd4, 8'd0);
        wr(3'd5, 8'hFF); wr(3'd6, 8'hFF); wr(3'd7, 8'hFF);

        // R3 R4 R6 R7: only channels 0 and 1 pass.
        tag = "R3 R4 R6 R7";
        pulse(1'b1, 4'hF); tick();
        // R5: repeated requests on held lanes merge.
        tag = "R5 merge";
        pulse(1'b1, 4'h8); pulse(1'b0, 4'h8); pulse(1'b1, 4'hC); tick();
        // R5: lowering the CPU level to 3 frees channel 2 only.
        tag = "R5 release by level";
        wr(3'd0, {1'b1, 1'b0, 3'd2, 3'd3}); tick(); tick();
        // R5: disabling frees the rest.
        tag = "R5 release by disable";
        wr(3'd0, {1'b0, 1'b0, 3'd2, 3'd3}); tick(); tick();

        // R10: mask ignored while auto is clear.
        tag = "R10";
        mask_sel = 1'b1; imask_lvl = 3'd6; tick(); tick();
        // R8: auto on with field style, including the write that sets it (R11).
        tag = "R8 R11";
        wr(3'd0, {1'b1, 1'b1, 3'd2, 3'd1});
        for (int v = 0; v < 8; v++) begin
            imask_lvl = 3'(v); pulse(1'b1, 4'hF);
        end
        wr(3'd0, {1'b1, 1'b1, 3'd4, 3'd0}); tick();
        // R9: single bit style.
        tag = "R9";
        mask_sel = 1'b0; imask_bit = 1'b1; pulse(1'b1, 4'hF); tick();
        imask_bit = 1'b0; tick(); tick();
        // R10: turning auto off freezes the level.
        tag = "R10 freeze";
        imask_bit = 1'b1; tick();
        wr(3'd0, {1'b1, 1'b0, 3'd4, 3'd6});
        imask_bit = 1'b0; mask_sel = 1'b1; imask_lvl = 3'd1; tick(); tick();

        // Random mix (R2 R3 R4 R5 R6 R8 R9 R11).
        tag = "random R3 R5 R8";
        for (int n = 0; n < 3000; n++) begin
            cfg_we    = ($urandom % 6) == 0;
            cfg_addr  = 3'($urandom);
            cfg_wdata = 8'($urandom);
            mask_sel  = 1'($urandom);
            imask_bit = 1'($urandom);
            imask_lvl = 3'($urandom);
            xfer_req  = ($urandom % 3) == 0;
            dma_req   = 4'($urandom) & 4'($urandom);
            tick();
        end
        tick(); tick();

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule